// File: doc/BRIEF.md
# Buffered Dual-Alignment PWM Channel

This block produces one pulse-width modulated output from an up/down counter. The counter moves only on cycles where the tick input from an external clock-source selector is high and the channel enable is set. Software writes period and duty bytes into shadow buffers. The buffers move into the active registers at the end of every effective period, or at once when software writes the counter. The output is either left-aligned, with a sawtooth count, or center-aligned, with a triangle count that rises to the period and falls back. A polarity input chooses which level is the active one.

Registers are reached through a byte-wide write port and a byte-wide combinational read port. When the pairing input is high, the counter, period and duty are 16 bits wide and each is reached as a low byte and a high byte. When it is low, only the low bytes take part. Reading never changes the channel. Writing either counter byte restarts the cycle.

Top module: `pwm_chan`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the counter and all buffers read 0, the count direction is up, and the output is low.
- R2: In left-aligned mode (center_mode=0) with period P>0, each advance step moves the count one up. A step taken at count P-1 returns it to 0, so one period lasts P steps.
- R3: In center-aligned mode (center_mode=1) with P>0, the count rises 0,1,..,P and then falls P-1,..,1. The step that would bring it to 0 ends the period, so one period lasts 2P steps.
- R4: An advance step happens only in a cycle with chan_en=1 and tick=1. In any other cycle the count and direction hold. When enable returns, counting goes on from the held value.
- R5: A write of any data to address 0 (count low byte) or address 1 (count high byte) sets the count to 0 and the direction to up in the next cycle. This holds in both modes and both widths.
- R6: A counter write copies the period buffer and the duty buffer into the active registers in the same edge. The output of the next cycle follows the new values.
- R7: Buffer writes go to address 2 (period low), 3 (period high), 4 (duty low) and 5 (duty high). They reach the active registers only at the end of a period, the step that returns the count to 0, or on a counter write.
- R8: The output is registered. After each edge it equals polarity when the count is below the active duty, and the inverse of polarity otherwise.
- R9: With an effective period of 0 the count stays at 0 and the output sits at the inverse of polarity. Each advance step reloads the buffers.
- R10: When the effective duty is greater than or equal to the effective period (period nonzero), the output stays at polarity for the whole cycle. This includes the top of a center-aligned count.
- R11: rd_data returns count low or high, period buffer low or high, or duty buffer low or high for rd_addr 0 to 5, and 0 for 6 and 7. Reads have no effect on the count or the output.
- R12: With cat_mode=1 the count, period and duty use all 16 bits. With cat_mode=0 only the low bytes are used, and the count high byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable from the selected clock source |
| chan_en | input | 1 | Channel enable; counter holds when low |
| center_mode | input | 1 | 1 = center-aligned, 0 = left-aligned |
| polarity | input | 1 | Active output level |
| cat_mode | input | 1 | 1 = 16-bit paired counter, 0 = 8-bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write address |
| wr_data | input | 8 | Register write byte |
| rd_sel | input | 3 | Register read address |
| rd_data | output | 8 | Register read byte, combinational |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench targets the period boundaries. If the left-aligned wrap is off by one, the sawtooth runs P+1 steps. If the center-aligned turn is off by one, the count either repeats the top value or lands on 0 one step late. Both show up as count and output mismatches. A design that loads buffers at a buffer write instead of at period end changes the running pulse width within the same period. A design that ignores a counter write made while disabled keeps a stale count and stale active registers. Period 0, duty at or above the period, and switching the width between 8 and 16 bits with nonzero high bytes are driven on purpose. A wrong mask makes the high byte leak into the 8-bit compare.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int CNT_W  = BYTE_W * LANES;
    localparam int SEL_W  = 3;

    typedef logic [CNT_W-1:0]  word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CNT_LO  = 3'd0,
        SEL_CNT_HI  = 3'd1,
        SEL_PER_LO  = 3'd2,
        SEL_PER_HI  = 3'd3,
        SEL_DUTY_LO = 3'd4,
        SEL_DUTY_HI = 3'd5
    } reg_sel_e;

    typedef struct packed {
        word_t period;
        word_t duty;
    } wave_cfg_t;

    // Effective value: full word when paired, low byte otherwise.
    function automatic word_t eff(input word_t v, input logic paired);
        return paired ? v : {{(CNT_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
    endfunction

    // Output level for a given count and active configuration.
    function automatic logic wave_level(input word_t cnt, input wave_cfg_t cfg,
                                        input logic pol, input logic paired);
        word_t c, p, d;
        c = eff(cnt, paired);
        p = eff(cfg.period, paired);
        d = eff(cfg.duty, paired);
        if (p == '0)       return ~pol;
        else if (d >= p)   return pol;
        else if (c < d)    return pol;
        else               return ~pol;
    endfunction

    function automatic logic is_cnt_sel(input logic [SEL_W-1:0] s);
        return (s == SEL_CNT_LO) || (s == SEL_CNT_HI);
    endfunction
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  byte_t            wr_data,
    input  logic             load,
    output wave_cfg_t        buf_cfg,
    output wave_cfg_t        act_cfg,
    output wave_cfg_t        act_nxt
);
    byte_t per_lane  [LANES];
    byte_t duty_lane [LANES];
    wave_cfg_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < LANES; b++) begin
                per_lane[b]  <= '0;
                duty_lane[b] <= '0;
            end
        end else if (wr_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (wr_sel == SEL_W'(int'(SEL_PER_LO) + b))  per_lane[b]  <= wr_data;
                if (wr_sel == SEL_W'(int'(SEL_DUTY_LO) + b)) duty_lane[b] <= wr_data;
            end
        end
    end

    always_comb begin
        for (int b = 0; b < LANES; b++) begin
            buf_cfg.period[b*BYTE_W +: BYTE_W] = per_lane[b];
            buf_cfg.duty[b*BYTE_W +: BYTE_W]   = duty_lane[b];
        end
    end

    assign act_nxt = load ? buf_cfg : act_q;

    always_ff @(posedge clk) begin
        if (rst) act_q <= '0;
        else     act_q <= act_nxt;
    end

    assign act_cfg = act_q;
endmodule

// File: rtl/pwm_count.sv
`timescale 1ns/1ps
module pwm_count
    import pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  adv,
    input  logic  center,
    input  logic  paired,
    input  word_t period,
    output word_t cnt_q,
    output logic  dir_dn,
    output word_t cnt_nxt,
    output logic  load
);
    word_t pe, ce, cnt_d;
    logic  dn_d, ld;

    always_comb begin
        pe    = eff(period, paired);
        ce    = eff(cnt_q, paired);
        cnt_d = cnt_q;
        dn_d  = dir_dn;
        ld    = 1'b0;
        if (clr) begin
            cnt_d = '0;
            dn_d  = 1'b0;
            ld    = 1'b1;
        end else if (adv) begin
            if (pe == '0) begin
                cnt_d = '0;
                dn_d  = 1'b0;
                ld    = 1'b1;
            end else if (!center) begin
                if (ce >= pe - word_t'(1)) begin
                    cnt_d = '0;
                    ld    = 1'b1;
                end else begin
                    cnt_d = ce + word_t'(1);
                end
                dn_d = 1'b0;
            end else if (dir_dn || ce >= pe) begin
                if (ce <= word_t'(1)) begin
                    cnt_d = '0;
                    dn_d  = 1'b0;
                    ld    = 1'b1;
                end else begin
                    cnt_d = ce - word_t'(1);
                    dn_d  = 1'b1;
                end
            end else begin
                cnt_d = ce + word_t'(1);
                dn_d  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            dir_dn <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            dir_dn <= dn_d;
        end
    end

    assign cnt_nxt = cnt_d;
    assign load    = ld;
endmodule

// File: rtl/pwm_wave.sv
`timescale 1ns/1ps
module pwm_wave
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  word_t     cnt_nxt,
    input  wave_cfg_t cfg_nxt,
    input  logic      pol,
    input  logic      paired,
    output logic      out_q
);
    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= wave_level(cnt_nxt, cfg_nxt, pol, paired);
    end
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             chan_en,
    input  logic             center_mode,
    input  logic             polarity,
    input  logic             cat_mode,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [7:0]       rd_data,
    output logic             pwm_out
);
    wave_cfg_t buf_cfg, act_cfg, act_nxt;
    word_t     cnt_q, cnt_nxt, cnt_vis;
    word_t     per_act, per_buf;
    logic      dir_dn, load, cnt_wr, adv;

    assign cnt_wr  = wr_en && is_cnt_sel(wr_sel);
    assign adv     = chan_en && tick;
    assign per_act = act_cfg.period;
    assign per_buf = buf_cfg.period;

    pwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (load),
        .buf_cfg (buf_cfg),
        .act_cfg (act_cfg),
        .act_nxt (act_nxt)
    );

    pwm_count u_count (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_wr),
        .adv     (adv),
        .center  (center_mode),
        .paired  (cat_mode),
        .period  (act_cfg.period),
        .cnt_q   (cnt_q),
        .dir_dn  (dir_dn),
        .cnt_nxt (cnt_nxt),
        .load    (load)
    );

    pwm_wave u_wave (
        .clk     (clk),
        .rst     (rst),
        .cnt_nxt (cnt_nxt),
        .cfg_nxt (act_nxt),
        .pol     (polarity),
        .paired  (cat_mode),
        .out_q   (pwm_out)
    );

    assign cnt_vis = eff(cnt_q, cat_mode);

    always_comb begin
        unique case (rd_sel)
            SEL_CNT_LO:  rd_data = cnt_vis[BYTE_W-1:0];
            SEL_CNT_HI:  rd_data = cnt_vis[CNT_W-1:BYTE_W];
            SEL_PER_LO:  rd_data = buf_cfg.period[BYTE_W-1:0];
            SEL_PER_HI:  rd_data = buf_cfg.period[CNT_W-1:BYTE_W];
            SEL_DUTY_LO: rd_data = buf_cfg.duty[BYTE_W-1:0];
            SEL_DUTY_HI: rd_data = buf_cfg.duty[CNT_W-1:BYTE_W];
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pwm_chan_chk.sv
`timescale 1ns/1ps
module pwm_chan_chk
    import pwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             chan_en,
    input logic             center_mode,
    input logic             cat_mode,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input word_t            cnt_q,
    input logic             dir_dn,
    input word_t            per_act,
    input word_t            per_buf
);
    logic  cwr, step;
    word_t pe, ce;
    assign cwr  = wr_en && ((wr_sel == SEL_CNT_LO) || (wr_sel == SEL_CNT_HI));
    assign step = chan_en && tick && !cwr;
    assign pe   = eff(per_act, cat_mode);
    assign ce   = eff(cnt_q, cat_mode);

    // R5
    cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        cwr |=> (cnt_q == '0 && !dir_dn));

    // R6
    restart_load_chk: assert property (@(posedge clk) disable iff (rst)
        cwr |=> (per_act == $past(per_buf)));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!(chan_en && tick) && !cwr) |=> ($stable(cnt_q) && $stable(dir_dn)));

    // R2
    left_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !center_mode && pe != '0 && ce >= pe - word_t'(1)) |=> (cnt_q == '0));

    // R3
    center_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (step && center_mode && !dir_dn && pe > word_t'(1) && ce == pe) |=> dir_dn);

    // R9
    zero_period_chk: assert property (@(posedge clk) disable iff (rst)
        (step && pe == '0) |=> (cnt_q == '0 && !dir_dn));
endmodule

bind pwm_chan pwm_chan_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .chan_en     (chan_en),
    .center_mode (center_mode),
    .cat_mode    (cat_mode),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .cnt_q       (cnt_q),
    .dir_dn      (dir_dn),
    .per_act     (per_act),
    .per_buf     (per_buf)
);

// File: tb/sim_pwm_chan.sv
`timescale 1ns/1ps
module sim_pwm_chan;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, chan_en = 1'b0, center_mode = 1'b0, polarity = 1'b0, cat_mode = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0, rd_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic pwm_out;

    int compared = 0, mismatched = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_chan u0 (
        .clk(clk), .rst(rst), .tick(tick), .chan_en(chan_en),
        .center_mode(center_mode), .polarity(polarity), .cat_mode(cat_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    // Reference model, built from the requirements.
    logic [15:0] m_cnt, m_per_b, m_duty_b, m_per_a, m_duty_a;
    logic m_dn, m_out;

    function automatic logic [15:0] f_eff(input logic [15:0] v, input logic p);
        return p ? v : {8'h00, v[7:0]};
    endfunction

    function automatic logic f_level(input logic [15:0] c, input logic [15:0] per,
                                     input logic [15:0] duty, input logic pol, input logic p);
        logic [15:0] ce, pe, de;
        ce = f_eff(c, p); pe = f_eff(per, p); de = f_eff(duty, p);
        if (pe == 16'd0) return ~pol;
        if (de >= pe)    return pol;
        return (ce < de) ? pol : ~pol;
    endfunction

    function automatic logic [7:0] f_read(input logic [2:0] s);
        logic [15:0] cv;
        cv = f_eff(m_cnt, cat_mode);
        case (s)
            3'd0: return cv[7:0];
            3'd1: return cv[15:8];
            3'd2: return m_per_b[7:0];
            3'd3: return m_per_b[15:8];
            3'd4: return m_duty_b[7:0];
            3'd5: return m_duty_b[15:8];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        logic ld;
        logic [15:0] pe, ce;
        if (rst) begin
            m_cnt = 0; m_dn = 0; m_per_b = 0; m_duty_b = 0;
            m_per_a = 0; m_duty_a = 0; m_out = 0;
        end else begin
            ld = 0;
            pe = f_eff(m_per_a, cat_mode);
            ce = f_eff(m_cnt, cat_mode);
            if (wr_en && wr_sel <= 3'd1) begin
                m_cnt = 0; m_dn = 0; ld = 1;
            end else if (chan_en && tick) begin
                if (pe == 0) begin
                    m_cnt = 0; m_dn = 0; ld = 1;
                end else if (!center_mode) begin
                    m_dn = 0;
                    if (ce + 1 >= pe) begin m_cnt = 0; ld = 1; end
                    else m_cnt = ce + 1;
                end else if (m_dn || ce >= pe) begin
                    if (ce <= 1) begin m_cnt = 0; m_dn = 0; ld = 1; end
                    else begin m_cnt = ce - 1; m_dn = 1; end
                end else begin
                    m_cnt = ce + 1;
                end
            end
            if (ld) begin m_per_a = m_per_b; m_duty_a = m_duty_b; end
            if (wr_en) begin
                case (wr_sel)
                    3'd2: m_per_b[7:0]   = wr_data;
                    3'd3: m_per_b[15:8]  = wr_data;
                    3'd4: m_duty_b[7:0]  = wr_data;
                    3'd5: m_duty_b[15:8] = wr_data;
                    default: ;
                endcase
            end
            m_out = f_level(m_cnt, m_per_a, m_duty_a, polarity, cat_mode);
        end
    end

    task automatic compare();
        logic [7:0] exp_rd;
        exp_rd = f_read(rd_sel);
        compared++;
        if (pwm_out !== m_out) begin
            mismatched++;
            $display("FAIL %s: pwm_out actual %0b expected %0b at %0t", tag, pwm_out, m_out, $time);
        end
        compared++;
        if (rd_data !== exp_rd) begin
            mismatched++;
            $display("FAIL %s: rd_data[%0d] actual %02h expected %02h at %0t",
                     tag, rd_sel, rd_data, exp_rd, $time);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        run(1);
        wr_en = 1'b0;
    endtask

    task automatic setcfg(input logic [15:0] per, input logic [15:0] duty);
        wr(3'd2, per[7:0]);  wr(3'd3, per[15:8]);
        wr(3'd4, duty[7:0]); wr(3'd5, duty[15:8]);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        tag = "R1";
        @(negedge clk);
        for (int s = 0; s < 3; s++) begin rd_sel = 3'(s); run(1); end
        rst = 1'b0;
        run(1);

        // R2 R8: left-aligned P=5 D=2, started by counter write (R6)
        tag = "R2 R6 R8";
        polarity = 1'b1; chan_en = 1'b1; tick = 1'b1; rd_sel = 3'd0;
        setcfg(16'd5, 16'd2);
        wr(3'd0, 8'h5A);
        run(14);

        // R7: buffer change mid-period takes effect only at period end
        tag = "R7";
        wr(3'd2, 8'd3); wr(3'd4, 8'd1);
        run(12);

        // R4: tick gating and disable hold
        tag = "R4";
        for (int i = 0; i < 10; i++) begin tick = i[0]; run(1); end
        tick = 1'b1; chan_en = 1'b0; run(6);
        chan_en = 1'b1; run(6);

        // R3: center-aligned P=4 D=1, polarity 0
        tag = "R3 R8";
        center_mode = 1'b1; polarity = 1'b0;
        setcfg(16'd4, 16'd1);
        wr(3'd1, 8'h00);
        run(20);
        center_mode = 1'b0; run(4);

        // R5: counter write while disabled still restarts
        tag = "R5";
        chan_en = 1'b0;
        wr(3'd0, 8'hFF);
        run(3);
        chan_en = 1'b1;

        // R9: period zero
        tag = "R9";
        setcfg(16'd0, 16'd3);
        wr(3'd0, 8'd0);
        run(8);

        // R10: duty at or above period, both modes
        tag = "R10";
        polarity = 1'b1;
        setcfg(16'd3, 16'd7);
        wr(3'd0, 8'd0);
        run(8);
        center_mode = 1'b1;
        wr(3'd2, 8'd3); wr(3'd4, 8'd3);
        wr(3'd0, 8'd0);
        run(10);
        center_mode = 1'b0;

        // R11: read sweep while disabled; nothing moves
        tag = "R11";
        chan_en = 1'b0;
        for (int s = 0; s < 8; s++) begin rd_sel = 3'(s); run(1); end
        chan_en = 1'b1;

        // R12: paired 16-bit counter, period 260, duty 128; high-byte restart
        tag = "R12";
        cat_mode = 1'b1; rd_sel = 3'd1;
        setcfg(16'd260, 16'd128);
        wr(3'd1, 8'h00);
        run(600);
        cat_mode = 1'b0; rd_sel = 3'd1;
        run(20);

        // Random mix
        tag = "R2 R3 R4 R5 R7 R12";
        for (int i = 0; i < 4000; i++) begin
            tick        = ($urandom % 4) != 0;
            chan_en     = ($urandom % 16) != 0;
            if ($urandom % 64 == 0) center_mode = ~center_mode;
            if ($urandom % 128 == 0) polarity = ~polarity;
            if ($urandom % 256 == 0) cat_mode = ~cat_mode;
            rd_sel = 3'($urandom % 8);
            wr_en  = ($urandom % 8) == 0;
            wr_sel = 3'($urandom % 6);
            case (wr_sel)
                3'd2:    wr_data = 8'($urandom % 12);
                3'd4:    wr_data = 8'($urandom % 14);
                3'd3, 3'd5: wr_data = ($urandom % 8 == 0) ? 8'd1 : 8'd0;
                default: wr_data = 8'($urandom);
            endcase
            run(1);
        end
        wr_en = 1'b0;
        run(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule